// File: doc/BRIEF.md
# Event-Interrupt UART

A serial port peripheral that sits on a simple 32-bit register bus. Software sees five word registers: a data register that both launches a transmit byte and returns the most recently received byte, a baud divisor, a status word, a control word and a debug word. The serial side runs fixed 8N1 framing: one low start bit, eight data bits least significant first, and one high stop bit. Every bit lasts divisor+1 clock cycles, and the idle line is high.

Events are sticky. Launching a byte raises a transmit event. Receiving a byte raises a receive event. Software clears either one by writing a 1 to its status bit. While the receive event is pending the single receive buffer is frozen, so frames that arrive in that time are thrown away. The transmit-empty status flag always reads 1. One level interrupt output is high whenever an enabled event is pending. The pass-through and break control bits are stored and read back, but they change nothing on the line or the interrupt.

Top module: `evt_uart`

## Requirements
- R1: After reset the status register reads 0x1, the data, divisor, control and debug registers read 0, irq is low and ser_tx is high.
- R2: Register index = byte address >> 2: 0 data, 1 divisor, 2 status, 3 control, 4 debug. Address bits [1:0] are ignored. Reads of indices 5 to 7 return 0, and writes to them change nothing.
- R3: Divisor, control and debug store all 32 written bits and read them back. Control bit 2 (pass-through) and debug bit 0 (break) have no effect on ser_tx or irq.
- R4: Status bit 0 always reads 1. A status write clears bit 1 and/or bit 2 wherever the written value has a 1, and leaves every other bit unchanged. Bits 31:3 read 0.
- R5: A data write sets status bit 2. If the transmitter is idle, the low 8 bits go out as a frame that starts on the accepting clock edge: start bit 0, data bits 0 to 7, stop bit 1, each held for divisor+1 cycles (low 16 bits of the divisor). Otherwise ser_tx stays high.
- R6: A frame occupies the transmitter for 10*(divisor+1) edges after its start edge. A data write on any of those edges, including the last one, is not sent but still sets status bit 2.
- R7: A received frame with a high stop bit puts its byte in data bits 7:0 (bits 31:8 read 0) and sets status bit 1. Counted from the last clock edge before the start bit's falling edge, this becomes visible after edge 9*(divisor+1) + floor(divisor/2) + 5.
- R8: While status bit 1 is set, received frames are discarded and the data register keeps its byte.
- R9: A frame whose stop bit is low is discarded: status bit 1 and the data register do not change.
- R10: irq = (control bit 0 AND status bit 1) OR (control bit 1 AND status bit 2). It follows register changes right after the edge that makes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the selected register |
| irq | output | 1 | Level interrupt |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
A wrong event bit shows up at irq after the very next edge as long as its enable is set, and it also shows up in any status read. A transmitter sequencing fault shows up on ser_tx within one bit period of the accepting write, because the line is compared against the expected frame on every cycle. A receiver that samples at the wrong point or ignores the pending event gives a wrong data readback or a misplaced receive event at the exact cycle given in R7.

// File: rtl/evt_uart_pkg.sv
package evt_uart_pkg;
  localparam int REG_DATA = 0;
  localparam int REG_DIV  = 1;
  localparam int REG_STAT = 2;
  localparam int REG_CTRL = 3;
  localparam int REG_DBG  = 4;
  localparam int NUM_REGS = 5;

  localparam int ST_THRE = 0;
  localparam int ST_RXE  = 1;
  localparam int ST_TXE  = 2;
  localparam int CT_RXIE = 0;
  localparam int CT_TXIE = 1;

  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  function automatic logic irq_eval(logic [1:0] en, logic rxe, logic txe);
    return (en[CT_RXIE] & rxe) | (en[CT_TXIE] & txe);
  endfunction

  function automatic logic [31:0] stat_word(logic rxe, logic txe);
    logic [31:0] w;
    w = '0;
    w[ST_THRE] = 1'b1;
    w[ST_RXE]  = rxe;
    w[ST_TXE]  = txe;
    return w;
  endfunction

  function automatic logic [FRAME_BITS-1:0] frame_pack(logic [BYTE_W-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction
endpackage

// File: rtl/evt_uart_sync.sv
module evt_uart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b1;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/evt_uart_tx.sv
module evt_uart_tx import evt_uart_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              go,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              busy,
  output logic              line
);
  localparam int NB_W = $clog2(FRAME_BITS);

  logic [DIV_W-1:0]      cnt;
  logic [NB_W-1:0]       nbit;
  logic [FRAME_BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '1;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= div;
        nbit <= '0;
        sh   <= frame_pack(byte_in);
      end
    end else if (cnt == '0) begin
      cnt <= div;
      if (nbit == NB_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
      end else begin
        sh   <= {1'b1, sh[FRAME_BITS-1:1]};
        nbit <= nbit + 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign line = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/evt_uart_rx.sv
module evt_uart_rx import evt_uart_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              line_in,
  output logic              done,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int NB_W = $clog2(BYTE_W);

  logic             s;
  rx_state_t        st;
  logic [DIV_W-1:0] cnt;
  logic [NB_W-1:0]  nbit;

  evt_uart_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .d(line_in), .q(s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      nbit     <= '0;
      byte_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        RX_IDLE: if (!s) begin
          st  <= RX_START;
          cnt <= div >> 1;
        end
        RX_START: if (cnt == '0) begin
          st   <= s ? RX_IDLE : RX_DATA;
          cnt  <= div;
          nbit <= '0;
        end else cnt <= cnt - 1'b1;
        RX_DATA: if (cnt == '0) begin
          byte_out <= {s, byte_out[BYTE_W-1:1]};
          cnt      <= div;
          if (nbit == NB_W'(BYTE_W - 1)) st <= RX_STOP;
          else nbit <= nbit + 1'b1;
        end else cnt <= cnt - 1'b1;
        RX_STOP: if (cnt == '0) begin
          done <= s;
          st   <= RX_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_uart.sv
module evt_uart import evt_uart_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              ser_rx,
  output logic              ser_tx
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    reg_idx;
  logic [NUM_REGS-1:0] hit;
  logic [31:0]         div_q, ctrl_q, dbg_q;
  logic [BYTE_W-1:0]   data_q, rx_byte;
  logic                rx_evt, tx_evt, rx_done, tx_busy;
  logic                wr_data, wr_div, wr_stat, wr_ctrl, wr_dbg;
  logic                tx_go, rx_accept, rx_drop;
  logic                unused_bits;

  assign reg_idx = bus_addr[ADDR_W-1:2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g] = bus_sel && (reg_idx == IDX_W'(g));
  end

  assign wr_data   = bus_we && hit[REG_DATA];
  assign wr_div    = bus_we && hit[REG_DIV];
  assign wr_stat   = bus_we && hit[REG_STAT];
  assign wr_ctrl   = bus_we && hit[REG_CTRL];
  assign wr_dbg    = bus_we && hit[REG_DBG];
  assign tx_go     = wr_data && !tx_busy;
  assign rx_accept = rx_done && !rx_evt;
  assign rx_drop   = rx_done && rx_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
      dbg_q  <= '0;
      data_q <= '0;
      rx_evt <= 1'b0;
      tx_evt <= 1'b0;
    end else begin
      if (wr_div)  div_q  <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_dbg)  dbg_q  <= bus_wdata;
      if (rx_accept) data_q <= rx_byte;
      rx_evt <= (rx_evt & ~(wr_stat & bus_wdata[ST_RXE])) | rx_accept;
      tx_evt <= (tx_evt & ~(wr_stat & bus_wdata[ST_TXE])) | wr_data;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit[REG_DATA]) bus_rdata = {{(32-BYTE_W){1'b0}}, data_q};
    if (hit[REG_DIV])  bus_rdata = div_q;
    if (hit[REG_STAT]) bus_rdata = stat_word(rx_evt, tx_evt);
    if (hit[REG_CTRL]) bus_rdata = ctrl_q;
    if (hit[REG_DBG])  bus_rdata = dbg_q;
  end

  assign irq = irq_eval(ctrl_q[1:0], rx_evt, tx_evt);

  evt_uart_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(div_q[DIV_W-1:0]), .go(tx_go),
    .byte_in(bus_wdata[BYTE_W-1:0]), .busy(tx_busy), .line(ser_tx));

  evt_uart_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(div_q[DIV_W-1:0]), .line_in(ser_rx),
    .done(rx_done), .byte_out(rx_byte));

  assign unused_bits = ^{bus_addr[1:0], div_q[31:DIV_W], rx_drop};
endmodule

// File: rtl/evt_uart_chk.sv
module evt_uart_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic              ser_tx,
  input logic              wr_data,
  input logic              wr_stat,
  input logic              wr_ctrl,
  input logic              tx_go,
  input logic              rx_done,
  input logic              rx_accept,
  input logic              rx_evt,
  input logic              tx_evt,
  input logic [1:0]        ctrl_lo,
  input logic [7:0]        data_q
);
  localparam int IDX_W = ADDR_W - 2;
  logic rd_stat, rd_hole;
  assign rd_stat = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] == IDX_W'(2));
  assign rd_hole = bus_sel && !bus_we && (bus_addr[ADDR_W-1:2] >= IDX_W'(5));

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hole |-> bus_rdata == 32'h0);
  assert_thre_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[0] && bus_rdata[31:3] == '0));
  assert_w1c_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[2] && !wr_data) |=> !tx_evt);
  assert_txe_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> tx_evt);
  assert_start_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !ser_tx);
  assert_rx_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> rx_evt);
  assert_rx_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_evt) |=> $stable(data_q));
  assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && ctrl_lo[0] && !wr_ctrl) |=> irq);
endmodule

bind evt_uart evt_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .ser_tx(ser_tx), .wr_data(wr_data), .wr_stat(wr_stat),
  .wr_ctrl(wr_ctrl), .tx_go(tx_go), .rx_done(rx_done), .rx_accept(rx_accept),
  .rx_evt(rx_evt), .tx_evt(tx_evt), .ctrl_lo(ctrl_q[1:0]), .data_q(data_q));

// File: tb/evt_uart_tb.sv
`timescale 1ns/1ps
module evt_uart_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, ser_rx = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, ser_tx;

  evt_uart u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ser_rx(ser_rx), .ser_tx(ser_tx));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  longint cyc = 0;
  logic [31:0] m_div = 0, m_ctrl = 0, m_dbg = 0;
  logic [7:0]  m_data = 0, tx_b = 0, rx_b = 0;
  bit m_rxe = 0, m_txe = 0, tx_act = 0;
  longint tx_e = 0, tx_p = 1, rx_due = -1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    case (a >> 2)
      0: return {24'h0, m_data};
      1: return m_div;
      2: return {29'h0, m_txe, m_rxe, 1'b1};
      3: return m_ctrl;
      4: return m_dbg;
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference: applied at each edge, compared between edges
  always @(posedge clk) begin
    longint n;
    bit old_rxe;
    n = cyc + 1;
    if (!rst_n) begin
      m_div = 0; m_ctrl = 0; m_dbg = 0; m_data = 0; m_rxe = 0; m_txe = 0; tx_act = 0;
    end else begin
      old_rxe = m_rxe;
      if (bus_sel && bus_we) begin
        case (int'(bus_addr) >> 2)
          0: begin
            m_txe = 1;
            if (!(tx_act && n <= tx_e + 10 * tx_p)) begin
              tx_act = 1; tx_e = n; tx_p = longint'(m_div & 32'hFFFF) + 1; tx_b = bus_wdata[7:0];
            end
          end
          1: m_div = bus_wdata;
          2: begin
            if (bus_wdata[1]) m_rxe = 0;
            if (bus_wdata[2]) m_txe = 0;
          end
          3: m_ctrl = bus_wdata;
          4: m_dbg = bus_wdata;
          default: ;
        endcase
      end
      if (n == rx_due && !old_rxe) begin
        m_rxe = 1; m_data = rx_b;
      end
    end
    cyc = n;
  end

  always @(negedge clk) begin
    logic exp_irq, exp_line;
    longint k;
    if (rst_n && !finished) begin
      exp_irq = (m_ctrl[0] & m_rxe) | (m_ctrl[1] & m_txe);
      chk(irq === exp_irq, "R10 irq", {31'h0, irq}, {31'h0, exp_irq});
      exp_line = 1'b1;
      if (tx_act && cyc < tx_e + 10 * tx_p) begin
        k = (cyc - tx_e) / tx_p;
        exp_line = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : tx_b[k-1];
      end
      chk(ser_tx === exp_line, "R5/R6 ser_tx", {31'h0, ser_tx}, {31'h0, exp_line});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, input string req);
    logic [31:0] e;
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a[4:0];
    #1;
    e = m_read(a);
    chk(bus_rdata === e, req, bus_rdata, e);
    bus_sel = 0;
  endtask

  task automatic rx_send(input logic [7:0] b, input bit good);
    int p, h;
    p = int'(m_div & 32'hFFFF) + 1;
    h = int'(m_div & 32'hFFFF) >> 1;
    @(negedge clk);
    if (good) begin rx_due = cyc + 5 + h + 9 * p; rx_b = b; end
    ser_rx = 0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin ser_rx = b[i]; repeat (p) @(negedge clk); end
    ser_rx = good; repeat (p) @(negedge clk);
    ser_rx = 1; repeat (2 * p) @(negedge clk);
  endtask

  task automatic finish_run;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 20; a += 4) rd(a, "R1 reset readback");
    chk(ser_tx === 1'b1, "R1 idle line", {31'h0, ser_tx}, 32'h1);
    // R3 plain storage, pass-through and break bits inert
    wr(4, 32'hDEAD_BEEF); rd(4, "R3 divisor");
    wr(12, 32'hFFFF_FFFC); rd(12, "R3 control");
    wr(16, 32'hFFFF_FFFF); rd(16, "R3 debug");
    // R2 holes and ignored low address bits
    wr(20, 32'h1234_5678); wr(28, 32'hFFFF_FFFF);
    rd(20, "R2 hole 5"); rd(24, "R2 hole 6"); rd(28, "R2 hole 7");
    rd(9, "R2 status via low bits"); rd(15, "R2 control via low bits");
    rd(4, "R2 divisor untouched"); rd(16, "R2 debug untouched");
    // R5 transmit
    wr(4, 15); wr(12, 0); wr(16, 0);
    wr(0, 32'h0000_01A5); rd(8, "R5 tx event set");
    // R6 write while busy is not sent
    wr(0, 32'h77); rd(8, "R6 event still set");
    repeat (170) @(negedge clk);
    // R4 write-one-to-clear
    wr(8, 32'h0); rd(8, "R4 zero write keeps events");
    wr(8, 32'hFFFF_FFFF); rd(8, "R4 clear both");
    // R10 tx interrupt
    wr(12, 2); rd(12, "R10 ctrl");
    wr(0, 32'h3C);
    repeat (170) @(negedge clk);
    wr(8, 4); rd(8, "R10 tx cleared");
    // R3 pass-through and break bits do not alter the frame
    wr(12, 6); wr(16, 1); wr(0, 32'h55);
    repeat (170) @(negedge clk);
    wr(8, 4); wr(16, 0);
    // R7 receive with rx interrupt
    wr(12, 1);
    rx_send(8'h3C, 1);
    rd(8, "R7 rx event"); rd(0, "R7 rx byte");
    // R8 frame dropped while event pending
    rx_send(8'h99, 1);
    rd(0, "R8 data kept"); rd(8, "R8 status");
    wr(8, 2); rd(8, "R4 rx cleared");
    rx_send(8'h81, 1); rd(0, "R7 second byte");
    wr(8, 2);
    // R9 bad stop bit
    rx_send(8'h42, 0);
    rd(8, "R9 no event"); rd(0, "R9 data kept");
    // another divisor: R5 and R7
    wr(4, 20); wr(12, 3);
    wr(0, 32'hC3);
    repeat (220) @(negedge clk);
    rx_send(8'hF0, 1);
    rd(0, "R7 byte at divisor 20"); rd(8, "R7 status at divisor 20");
    wr(8, 6); rd(8, "R4 final clear");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule